// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block is the serial sample port of a voice codec. It moves one 8-bit sample each way per frame over a single shared timeslot. An active-high strobe, repeating at the 8 kHz frame rate, marks that timeslot. While the strobe is high, the port shifts a transmit byte out MSB first and gathers a receive byte from the serial input, also MSB first. The transmit byte is taken from a parallel input when the strobe rises. The received byte is handed on with a one-cycle valid pulse after its eighth bit.

Each direction has its own mute input. A mute replaces the live sample on its path with the negative-zero quiet code of the selected companding law. A 3-bit clock-select input is decoded into the bit rate in kHz. The decode also raises a flag when the bit rate is too low to clock the internal logic, which means a separate 4.096 MHz master clock is needed. The two unused select codes raise an error and hold the port idle.

The bit clock, strobe and serial input are sampled by the block's system clock. The bit clock is assumed to run well below half the system clock rate. Edges are found from registered copies of the inputs.

Top module: `pcm_strobe_port`

## Requirements
- R1: `bit_rate_khz` decodes `clk_sel` as follows: 3'b000→512, 3'b001→1536, 3'b010→2048, 3'b011→4096, 3'b100→128, 3'b101→256. Codes 3'b110 and 3'b111 give 0.
- R2: `need_mclk` is 1 only for `clk_sel` 3'b100 and 3'b101 (128 and 256 kHz). It is 0 for every other code.
- R3: `sel_error` is 1 for `clk_sel` 3'b110 and 3'b111. While it is 1, the port is idle: `dout_oe` stays 0 and `rx_valid` never pulses, even if a full strobed frame arrives.
- R4: On the strobe's rising edge, `tx_byte` is loaded and its bit 7 appears on `dout` first. This holds even when the strobe rises together with a bit-clock rising edge. Each later bit-clock rising edge inside the slot moves on to the next lower bit.
- R5: `dout_oe` is 1 only during a strobe-high slot that started while the port was not idle. It returns to 0 after the strobe falls, and `dout` reads 0 while `dout_oe` is 0.
- R6: `din` is sampled on each falling bit-clock edge inside the slot, MSB first. After the eighth falling edge, `rx_valid` pulses for exactly one system-clock cycle, with the assembled byte on `rx_byte`.
- R7: If `tx_mute` is 1 when the strobe rises, the slot sends the quiet code instead of `tx_byte`. The quiet code is 8'h7F when `law_alaw`=0 (mu-law) and 8'h55 when `law_alaw`=1 (A-law).
- R8: If `rx_mute` is 1 when the eighth bit is taken, `rx_byte` carries the quiet code of R7 instead of the received byte.
- R9: With both mutes at 0, both paths carry live data, including after a muted frame.
- R10: After a synchronous active-low reset, `dout_oe`, `dout`, `rx_valid` and `rx_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Bit-rate select code |
| law_alaw | input | 1 | Companding law for the quiet code: 0 mu-law, 1 A-law |
| bclk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for dout, high only inside the slot |
| tx_byte | input | 8 | Parallel sample to transmit |
| tx_mute | input | 1 | Send the quiet code on the transmit path |
| rx_mute | input | 1 | Deliver the quiet code on the receive path |
| rx_byte | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| need_mclk | output | 1 | Selected bit rate needs a separate master clock |
| bit_rate_khz | output | 13 | Decoded bit rate in kHz |
| sel_error | output | 1 | Unused select code; port held idle |

## Verification
Two events can land in the same cycle. The strobe's rising edge loads the transmit byte, and a bit-clock rising edge would normally shift it. The bench starts every frame by raising the strobe and the bit clock on the same system-clock edge. Patterns 8'h80 and 8'h01 then show whether the first serial bit is bit 7, or whether the shift has already consumed it. A second overlap happens at the end of the slot. The eighth falling edge fires the receive pulse while the strobe is about to drop. The bench counts exactly one pulse per frame and checks the byte it carries, and it checks that the output enable falls after the strobe.

// File: rtl/pcm_port_pkg.sv
// Shared constants, select-code type and quiet-code helper for the PCM port.
// Assumes 8-bit companded samples; quiet codes are the negative-zero values.
package pcm_port_pkg;

    localparam int SAMPLE_W = 8;
    localparam int RATE_W   = 13;

    localparam logic [SAMPLE_W-1:0] QUIET_MU = 8'h7F;
    localparam logic [SAMPLE_W-1:0] QUIET_A  = 8'h55;

    typedef enum logic [2:0] {
        SEL_512  = 3'b000,
        SEL_1536 = 3'b001,
        SEL_2048 = 3'b010,
        SEL_4096 = 3'b011,
        SEL_128  = 3'b100,
        SEL_256  = 3'b101,
        SEL_RSV6 = 3'b110,
        SEL_RSV7 = 3'b111
    } clk_sel_e;

    // Returns the negative-zero code of the selected law.
    function automatic logic [SAMPLE_W-1:0] quiet_code(input logic alaw);
        return alaw ? QUIET_A : QUIET_MU;
    endfunction

endpackage

// File: rtl/pcm_clksel_decode.sv
// Decodes the 3-bit clock-select code into a bit rate, a master-clock
// requirement and an error flag for the two unused codes.
// Assumes clk_sel is static or changes only between frames.
module pcm_clksel_decode
    import pcm_port_pkg::*;
#(
    parameter int RATE_BITS = RATE_W
) (
    input  logic [2:0]           clk_sel,
    output logic [RATE_BITS-1:0] rate_khz,
    output logic                 need_mclk,
    output logic                 sel_err
);

    // Purpose: map each select code to its rate and flags.
    always_comb begin
        rate_khz  = '0;
        need_mclk = 1'b0;
        sel_err   = 1'b0;
        case (clk_sel_e'(clk_sel))
            SEL_512:  rate_khz = RATE_BITS'(512);
            SEL_1536: rate_khz = RATE_BITS'(1536);
            SEL_2048: rate_khz = RATE_BITS'(2048);
            SEL_4096: rate_khz = RATE_BITS'(4096);
            SEL_128:  begin rate_khz = RATE_BITS'(128); need_mclk = 1'b1; end
            SEL_256:  begin rate_khz = RATE_BITS'(256); need_mclk = 1'b1; end
            default:  sel_err = 1'b1;
        endcase
    end

    // Purpose: a master-clock demand only ever comes with a sub-512 kHz rate (R2).
    always_comb begin
        if (!$isunknown(clk_sel))
            p_mclk_low_rate_r2: assert (!need_mclk || (rate_khz < RATE_BITS'(512) && !sel_err));
    end

endmodule

// File: rtl/pcm_edge_sync.sv
// Registers the bit clock, strobe and serial input on the system clock and
// derives single-cycle edge indications from them.
// Assumes the bit clock period spans at least four system-clock cycles.
module pcm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic strobe,
    input  logic din,
    output logic bit_rise,
    output logic bit_fall,
    output logic slot_start,
    output logic slot_lvl,
    output logic din_bit
);

    logic bclk_s, bclk_p, strb_s, strb_p, din_s;

    // Purpose: capture inputs and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s <= 1'b0;
            bclk_p <= 1'b0;
            strb_s <= 1'b0;
            strb_p <= 1'b0;
            din_s  <= 1'b0;
        end else begin
            bclk_s <= bclk;
            bclk_p <= bclk_s;
            strb_s <= strobe;
            strb_p <= strb_s;
            din_s  <= din;
        end
    end

    assign bit_rise   = bclk_s & ~bclk_p;
    assign bit_fall   = ~bclk_s & bclk_p;
    assign slot_start = strb_s & ~strb_p;
    assign slot_lvl   = strb_s;
    assign din_bit    = din_s;

endmodule

// File: rtl/pcm_tx_shifter.sv
// Loads the transmit sample (or quiet code) at slot start and shifts it out
// MSB first on bit-clock rising edges; drives the output enable for the slot.
// Assumes edge strobes come from pcm_edge_sync; a slot start beats a shift.
module pcm_tx_shifter
    import pcm_port_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              slot_start,
    input  logic              slot_lvl,
    input  logic              bit_rise,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_mute,
    input  logic              law_alaw,
    output logic              dout,
    output logic              dout_oe
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sreg;
    logic [CNT_W-1:0]  idx;
    logic              oe;

    // Purpose: slot load, per-bit shift and output-enable control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
            oe   <= 1'b0;
        end else if (halt) begin
            idx <= '0;
            oe  <= 1'b0;
        end else if (slot_start) begin
            sreg <= tx_mute ? DATA_W'(quiet_code(law_alaw)) : tx_byte;
            idx  <= '0;
            oe   <= 1'b1;
        end else if (!slot_lvl) begin
            oe <= 1'b0;
        end else if (oe && bit_rise && idx < CNT_W'(DATA_W - 1)) begin
            sreg <= {sreg[DATA_W-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign dout    = oe ? sreg[DATA_W-1] : 1'b0;
    assign dout_oe = oe;

    // Purpose: enable never outlives the strobe by more than the sync cycle (R5).
    p_oe_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_lvl |=> !dout_oe);

    // Purpose: serial data moves only after a bit-clock rise or a load (R4).
    p_dout_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_lvl && !halt && !slot_start && !bit_rise) |=> $stable(dout));

endmodule

// File: rtl/pcm_rx_shifter.sv
// Collects serial bits on bit-clock falling edges within the slot and
// presents the byte (or the quiet code when muted) with a one-cycle pulse.
// Assumes edge strobes come from pcm_edge_sync; one byte per slot.
module pcm_rx_shifter
    import pcm_port_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              slot_start,
    input  logic              slot_lvl,
    input  logic              bit_fall,
    input  logic              din_bit,
    input  logic              rx_mute,
    input  logic              law_alaw,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] byte_q;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    logic              valid_q;

    // Purpose: arm at slot start, gather bits, and publish the finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            byte_q  <= '0;
            cnt     <= '0;
            armed   <= 1'b0;
            valid_q <= 1'b0;
        end else if (halt) begin
            cnt     <= '0;
            armed   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (slot_start) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (!slot_lvl) begin
                armed <= 1'b0;
            end else if (armed && bit_fall) begin
                sreg <= {sreg[DATA_W-2:0], din_bit};
                cnt  <= cnt + 1'b1;
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    armed   <= 1'b0;
                    valid_q <= 1'b1;
                    byte_q  <= rx_mute ? DATA_W'(quiet_code(law_alaw))
                                       : {sreg[DATA_W-2:0], din_bit};
                end
            end
        end
    end

    assign rx_byte  = byte_q;
    assign rx_valid = valid_q;

    // Purpose: the receive pulse is a single cycle wide (R6).
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // Purpose: an idle port produces no receive pulse (R3).
    p_no_valid_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !rx_valid);

endmodule

// File: rtl/pcm_strobe_port.sv
// Top of the strobed PCM serial port: one shared 8-bit slot per frame,
// per-direction quiet-code mute and bit-rate select decode.
// Assumes bclk, strobe and din are slow relative to clk.
module pcm_strobe_port
    import pcm_port_pkg::*;
#(
    parameter int DATA_W    = SAMPLE_W,
    parameter int RATE_BITS = RATE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           clk_sel,
    input  logic                 law_alaw,
    input  logic                 bclk,
    input  logic                 strobe,
    input  logic                 din,
    output logic                 dout,
    output logic                 dout_oe,
    input  logic [DATA_W-1:0]    tx_byte,
    input  logic                 tx_mute,
    input  logic                 rx_mute,
    output logic [DATA_W-1:0]    rx_byte,
    output logic                 rx_valid,
    output logic                 need_mclk,
    output logic [RATE_BITS-1:0] bit_rate_khz,
    output logic                 sel_error
);

    logic bit_rise, bit_fall, slot_start, slot_lvl, din_bit;

    pcm_clksel_decode #(.RATE_BITS(RATE_BITS)) u_decode (
        .clk_sel   (clk_sel),
        .rate_khz  (bit_rate_khz),
        .need_mclk (need_mclk),
        .sel_err   (sel_error)
    );

    pcm_edge_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .strobe     (strobe),
        .din        (din),
        .bit_rise   (bit_rise),
        .bit_fall   (bit_fall),
        .slot_start (slot_start),
        .slot_lvl   (slot_lvl),
        .din_bit    (din_bit)
    );

    pcm_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (sel_error),
        .slot_start (slot_start),
        .slot_lvl   (slot_lvl),
        .bit_rise   (bit_rise),
        .tx_byte    (tx_byte),
        .tx_mute    (tx_mute),
        .law_alaw   (law_alaw),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    pcm_rx_shifter #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (sel_error),
        .slot_start (slot_start),
        .slot_lvl   (slot_lvl),
        .bit_fall   (bit_fall),
        .din_bit    (din_bit),
        .rx_mute    (rx_mute),
        .law_alaw   (law_alaw),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid)
    );

    // Purpose: an unused select code keeps the transmit driver off (R3).
    p_err_keeps_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_error |=> !dout_oe);

endmodule

// File: tb/pcm_strobe_port_tb.sv
// Directed bench for pcm_strobe_port: one task per scenario, each self-checking.
module pcm_strobe_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'b000;
    logic        law_alaw = 1'b0;
    logic        bclk = 1'b0;
    logic        strobe = 1'b0;
    logic        din = 1'b0;
    logic        dout, dout_oe;
    logic [7:0]  tx_byte = 8'h00;
    logic        tx_mute = 1'b0;
    logic        rx_mute = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        need_mclk;
    logic [12:0] bit_rate_khz;
    logic        sel_error;

    int n_checks = 0;
    int n_fail   = 0;
    int v_count  = 0;
    logic [7:0] v_last = 8'h00;

    always #5 clk = ~clk;

    pcm_strobe_port u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .law_alaw(law_alaw),
        .bclk(bclk), .strobe(strobe), .din(din), .dout(dout), .dout_oe(dout_oe),
        .tx_byte(tx_byte), .tx_mute(tx_mute), .rx_mute(rx_mute),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .need_mclk(need_mclk),
        .bit_rate_khz(bit_rate_khz), .sel_error(sel_error)
    );

    // Receive-pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            v_count <= v_count + 1;
            v_last  <= rx_byte;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One full strobed slot: strobe rises with the first bit-clock rise.
    task automatic run_frame(input logic [7:0] rx_pat, output logic [7:0] got,
                             output int oe_lo, output logic oe_after);
        oe_lo = 0;
        got   = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) strobe = 1'b1;
            bclk = 1'b1;
            din  = rx_pat[7-i];
            repeat (8) @(negedge clk);
            got[7-i] = dout;
            if (!dout_oe) oe_lo++;
            bclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        strobe = 1'b0;
        repeat (4) @(negedge clk);
        oe_after = dout_oe;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 dout_oe", dout_oe, 0);
        chk("R10 dout", dout, 0);
        chk("R10 rx_valid", rx_valid, 0);
        chk("R10 rx_byte", rx_byte, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_clksel();
        logic [12:0] exp_rate [8] = '{13'd512, 13'd1536, 13'd2048, 13'd4096,
                                      13'd128, 13'd256, 13'd0, 13'd0};
        for (int c = 0; c < 8; c++) begin
            clk_sel = 3'(c);
            @(negedge clk);
            chk("R1 rate", bit_rate_khz, exp_rate[c]);
            chk("R2 need_mclk", need_mclk, (c == 4 || c == 5) ? 1 : 0);
            chk("R3 sel_error", sel_error, (c >= 6) ? 1 : 0);
        end
        clk_sel = 3'b000;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_live(input logic [7:0] txv, input logic [7:0] rxv, input string req);
        logic [7:0] got; int oe_lo; logic oe_after; int v0;
        tx_byte = txv;
        v0 = v_count;
        run_frame(rxv, got, oe_lo, oe_after);
        chk({req, " R4 tx bits"}, got, txv);
        chk("R5 oe in slot", oe_lo, 0);
        chk("R5 oe after slot", oe_after, 0);
        chk("R6 one pulse", v_count - v0, 1);
        chk({req, " R6 rx byte"}, v_last, rxv);
    endtask

    task automatic t_tx_mute(input logic alaw, input logic [7:0] quiet);
        logic [7:0] got; int oe_lo; logic oe_after;
        law_alaw = alaw; tx_mute = 1'b1; tx_byte = 8'hC3;
        run_frame(8'h00, got, oe_lo, oe_after);
        chk("R7 tx quiet", got, quiet);
        tx_mute = 1'b0;
    endtask

    task automatic t_rx_mute(input logic alaw, input logic [7:0] quiet);
        logic [7:0] got; int oe_lo; logic oe_after; int v0;
        law_alaw = alaw; rx_mute = 1'b1; tx_byte = 8'h00;
        v0 = v_count;
        run_frame(8'hE1, got, oe_lo, oe_after);
        chk("R8 rx pulse", v_count - v0, 1);
        chk("R8 rx quiet", v_last, quiet);
        rx_mute = 1'b0;
    endtask

    task automatic t_bad_sel();
        logic [7:0] got; int oe_lo; logic oe_after; int v0;
        for (int c = 6; c < 8; c++) begin
            clk_sel = 3'(c); tx_byte = 8'hFF;
            v0 = v_count;
            run_frame(8'hA5, got, oe_lo, oe_after);
            chk("R3 oe stays low", oe_lo, 8);
            chk("R3 dout quiet", got, 0);
            chk("R3 no rx pulse", v_count - v0, 0);
        end
        clk_sel = 3'b000;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clksel();
        t_live(8'hA5, 8'h3C, "R4");
        t_live(8'h80, 8'h01, "R4 msb-first");
        t_live(8'h01, 8'h80, "R6 msb-first");
        t_tx_mute(1'b0, 8'h7F);
        t_tx_mute(1'b1, 8'h55);
        t_rx_mute(1'b1, 8'h55);
        t_rx_mute(1'b0, 8'h7F);
        t_live(8'h5A, 8'hC6, "R9 after mute");
        t_bad_sel();
        t_live(8'h96, 8'h69, "R9 after error");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule